// File: doc/BRIEF.md
# Per-Channel Idle Code and Loopback Inserter

This block sits in a serial E1 bit stream: 32 timeslots of 8 bits per frame, each timeslot sent most significant bit first, timeslot 0 first in the frame. It overwrites the timeslots chosen by a 32-bit channel mask. In idle mode every chosen timeslot carries a programmable 8-bit idle code. In loopback mode every chosen timeslot carries the bits present at the same moment on a second serial input, which carries the received data. Timeslots that are not chosen go through unchanged.

A single frame pulse aligns the internal bit and timeslot counters. Software writes the mask, the idle code and the mode through a small register write port. Writes land in shadow registers, and the shadow registers are copied into the working set at the next frame pulse. This means a timeslot is never replaced partway through. The same block serves the transmit path or the receive path.

Top module: `chan_idle_loop_insert`

## Requirements
- R1: While `rst_n` is low, `ser_out` is 0 after each clock edge. After reset, every channel is unselected, so `ser_out` at cycle t+1 equals `ser_in` at cycle t.
- R2: For a bit in an unselected timeslot, `ser_out` one clock later equals `ser_in`.
- R3: With mode 0 (idle), a bit in a selected timeslot is replaced one clock later by the idle code bit for its position. Bit position 0 of the timeslot takes idle code bit 7, and bit position 7 takes idle code bit 0.
- R4: With mode 1 (loopback), a bit in a selected timeslot is replaced one clock later by the `lb_in` value from the same cycle.
- R5: Writing address k (0 to 3) sets mask byte k. Bit b of that byte selects timeslot 8*k+b, so address 0 bit 0 is timeslot 0 and address 3 bit 7 is timeslot 31. Address 4 holds the idle code. Bit 0 of address 5 holds the mode.
- R6: A register write has no effect on the output until the next `frame_pulse`. The new settings apply from the bit that arrives with that pulse.
- R7: A `frame_pulse` marks its own cycle as timeslot 0, bit position 0, and the counting restarts from there. This holds even when the pulse arrives partway through a frame.
- R8: Writes to addresses 6 and 7 are ignored.
- R9: With no `frame_pulse`, the counters wrap from timeslot 31 bit position 7 to timeslot 0 bit position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-cycle pulse, arrives with the MSB of timeslot 0 |
| ser_in | input | 1 | Serial data to pass or overwrite |
| lb_in | input | 1 | Received serial data, used as the loopback source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ser_out | output | 1 | Serial data after insertion |

## Verification
Every output bit is due exactly one clock after the input bit it belongs to. The bench drives inputs on the falling edge. It predicts the output bit from a model of its own, built from its own position counter and its own shadow and working register set. It then compares that prediction with `ser_out` at the next falling edge, which falls after the single register stage. A write in the same cycle as a frame pulse reaches only the shadow registers, so the model applies the pulse before the write. The same rule governs writes made mid-frame, which must not show until the following pulse. Directed frames cover the mask bit mapping, a realigning mid-frame pulse, a frame boundary with no pulse, and writes to unused addresses. Seeded random frames add mixed writes and data.

// File: rtl/cil_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the idle/loopback inserter.
package cil_pkg;
    // What a selected timeslot is filled with.
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_LOOP = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/cil_slot_counter.sv
`timescale 1ns/1ps
// Slot counter: tracks which timeslot and bit position the current serial bit
// belongs to. Assumes frame_pulse is high for the first bit of timeslot 0 and
// that BITS > 1. Without a pulse the count wraps once per frame.
module cil_slot_counter #(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit
);
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;

    // The pulse forces the present bit to position zero.
    assign cur_slot = frame_pulse ? '0 : slot_q;
    assign cur_bit  = frame_pulse ? '0 : bit_q;

    // Advance to the position of the next serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else if (cur_bit == BIT_W'(BITS - 1)) begin
            bit_q  <= '0;
            slot_q <= (cur_slot == SLOT_W'(SLOTS - 1)) ? '0 : cur_slot + 1'b1;
        end else begin
            bit_q  <= cur_bit + 1'b1;
            slot_q <= cur_slot;
        end
    end

    // R7
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (bit_q == BIT_W'(1) && slot_q == '0));

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && slot_q == SLOT_W'(SLOTS - 1) && bit_q == BIT_W'(BITS - 1))
        |=> (bit_q == '0 && slot_q == '0));
endmodule

// File: rtl/cil_cfg_regs.sv
`timescale 1ns/1ps
// Configuration registers: writes go to a shadow set. The shadow set is
// copied to the working set on frame_pulse. While the pulse is high the
// outputs show the shadow values, so new settings start with the first bit
// of the frame. Mask bytes sit at addresses 0..SLOTS/BITS-1, the idle code at
// the next address, and the mode bit (data bit 0) at the one after. All other
// addresses are ignored.
module cil_cfg_regs
    import cil_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int BITS   = 8,
    parameter int ADDR_W = 3,
    localparam int REG_CNT   = SLOTS / BITS,
    localparam int IDLE_ADDR = REG_CNT,
    localparam int MODE_ADDR = REG_CNT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BITS-1:0]   wr_data,
    output logic [SLOTS-1:0]  mask_now,
    output logic [BITS-1:0]   idle_now,
    output fill_mode_e        mode_now
);
    logic [SLOTS-1:0] sh_mask, act_mask;
    logic [BITS-1:0]  sh_idle, act_idle;
    fill_mode_e       sh_mode, act_mode;
    logic [REG_CNT-1:0] byte_hit;
    logic idle_hit, mode_hit;

    // One address decoder per mask byte.
    for (genvar g = 0; g < REG_CNT; g++) begin : g_dec
        assign byte_hit[g] = wr_en && (wr_addr == ADDR_W'(g));
    end
    assign idle_hit = wr_en && (wr_addr == ADDR_W'(IDLE_ADDR));
    assign mode_hit = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

    // Capture software writes into the shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mask <= '0;
            sh_idle <= '0;
            sh_mode <= FILL_IDLE;
        end else begin
            for (int k = 0; k < REG_CNT; k++) begin
                if (byte_hit[k]) sh_mask[k*BITS +: BITS] <= wr_data;
            end
            if (idle_hit) sh_idle <= wr_data;
            if (mode_hit) sh_mode <= fill_mode_e'(wr_data[0]);
        end
    end

    // Copy shadow to working set at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mask <= '0;
            act_idle <= '0;
            act_mode <= FILL_IDLE;
        end else if (frame_pulse) begin
            act_mask <= sh_mask;
            act_idle <= sh_idle;
            act_mode <= sh_mode;
        end
    end

    assign mask_now = frame_pulse ? sh_mask : act_mask;
    assign idle_now = frame_pulse ? sh_idle : act_idle;
    assign mode_now = frame_pulse ? sh_mode : act_mode;

    // R6
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> ($stable(act_mask) && $stable(act_idle) && $stable(act_mode)));
endmodule

// File: rtl/cil_bit_mux.sv
`timescale 1ns/1ps
// Bit mux: picks pass-through, idle bit or loopback bit for the current
// serial bit and registers it. This register is the block's single clock of
// latency.
module cil_bit_mux
    import cil_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_sel,
    input  fill_mode_e mode,
    input  logic       idle_bit,
    input  logic       ser_in,
    input  logic       lb_in,
    output logic       ser_out
);
    logic next_bit;

    // Choose the outgoing bit.
    always_comb begin
        if (!chan_sel)              next_bit = ser_in;
        else if (mode == FILL_LOOP) next_bit = lb_in;
        else                        next_bit = idle_bit;
    end

    // Register the outgoing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) ser_out <= 1'b0;
        else        ser_out <= next_bit;
    end
endmodule

// File: rtl/chan_idle_loop_insert.sv
`timescale 1ns/1ps
// Per-channel idle code and loopback inserter. The timeslots marked in the
// mask are overwritten with either the idle code (MSB first) or the
// loopback input. Every bit leaves one clock after it arrives. Assumes a
// frame_pulse on the first bit of timeslot 0 and serves either the transmit
// or the receive path.
module chan_idle_loop_insert
    import cil_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int BITS   = 8,
    parameter int ADDR_W = 3,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              ser_in,
    input  logic              lb_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BITS-1:0]   wr_data,
    output logic              ser_out
);
    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;
    logic [SLOTS-1:0]  mask_now;
    logic [BITS-1:0]   idle_now;
    fill_mode_e        mode_now;
    logic              chan_sel;
    logic              idle_bit;

    cil_slot_counter #(.SLOTS(SLOTS), .BITS(BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .cur_slot(cur_slot), .cur_bit(cur_bit)
    );

    cil_cfg_regs #(.SLOTS(SLOTS), .BITS(BITS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mask_now(mask_now), .idle_now(idle_now), .mode_now(mode_now)
    );

    // Look up the select bit and the idle bit, MSB first.
    assign chan_sel = mask_now[cur_slot];
    assign idle_bit = idle_now[BIT_W'(BITS - 1) - cur_bit];

    cil_bit_mux u_mux (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .mode(mode_now),
        .idle_bit(idle_bit), .ser_in(ser_in), .lb_in(lb_in), .ser_out(ser_out)
    );

    // R2
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_sel |=> (ser_out == $past(ser_in)));

    // R3
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel && mode_now == FILL_IDLE) |=> (ser_out == $past(idle_bit)));

    // R4
    loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel && mode_now == FILL_LOOP) |=> (ser_out == $past(lb_in)));
endmodule

// File: tb/sim_chan_idle_loop_insert.sv
`timescale 1ns/1ps
module sim_chan_idle_loop_insert;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       ser_in = 1'b0;
    logic       lb_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ser_out;

    chan_idle_loop_insert u0 (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .lb_in(lb_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ser_out(ser_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string tag = "R1";
    string exp_tag = "R1";
    logic exp_q = 1'b0;
    bit exp_valid = 0;

    // Bench model of the register sets and position.
    logic [31:0] m_sh_mask = '0, m_mask = '0;
    logic [7:0]  m_sh_idle = '0, m_idle = '0;
    logic        m_sh_mode = 1'b0, m_mode = 1'b0;
    int m_slot = 0, m_bit = 0;

    task automatic check_bit(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic predict(logic s, logic l);
        if (!m_mask[m_slot]) predict = s;
        else if (m_mode)     predict = l;
        else                 predict = m_idle[7 - m_bit];
    endfunction

    // One bit cycle: check the previous bit, drive, model, wait.
    task automatic step(logic fp, logic s, logic l, logic we, logic [2:0] a, logic [7:0] d);
        if (exp_valid) check_bit(exp_tag, ser_out, exp_q);
        frame_pulse = fp; ser_in = s; lb_in = l;
        wr_en = we; wr_addr = a; wr_data = d;
        if (fp) begin
            m_mask = m_sh_mask; m_idle = m_sh_idle; m_mode = m_sh_mode;
            m_slot = 0; m_bit = 0;
        end
        exp_q = predict(s, l);
        if (!m_mask[m_slot]) exp_tag = {tag, "/R2"};
        else if (m_mode)     exp_tag = {tag, "/R4"};
        else                 exp_tag = {tag, "/R3"};
        if (we) begin
            if (a < 3'd4)       m_sh_mask[a*8 +: 8] = d;
            else if (a == 3'd4) m_sh_idle = d;
            else if (a == 3'd5) m_sh_mode = d[0];
        end
        if (m_bit == 7) begin
            m_bit = 0;
            m_slot = (m_slot == 31) ? 0 : m_slot + 1;
        end else m_bit++;
        exp_valid = 1;
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        step(1'b0, 1'($urandom), 1'($urandom), 1'b1, a, d);
    endtask

    task automatic rand_frame(int n, bit writes);
        for (int c = 0; c < n; c++) begin
            logic we;
            we = writes && ($urandom % 24 == 0);
            step(c == 0, 1'($urandom), 1'($urandom), we, 3'($urandom % 6), 8'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        ser_in = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_bit("R1", ser_out, 1'b0);
        end
        rst_n = 1'b1;
        tag = "R1";
        for (int i = 0; i < 40; i++) step(1'b0, 1'($urandom), 1'($urandom), 1'b0, 3'd0, 8'd0);

        // R6 and R9: writes mid-frame stay hidden, wrap without pulse
        tag = "R6";
        wr(3'd0, 8'h01);
        wr(3'd4, 8'hA5);
        wr(3'd5, 8'h00);
        tag = "R9";
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 8'd0);
        tag = "R3";
        rand_frame(256, 0);

        // R5: mask mapping
        tag = "R5";
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h20);
        wr(3'd3, 8'h80);
        wr(3'd4, 8'h3C);
        for (int i = 0; i < 256; i++) step(i == 0, 1'b1, 1'b1, 1'b0, 3'd0, 8'd0);
        wr(3'd0, 8'h01);
        for (int i = 0; i < 256; i++) step(i == 0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0);

        // R4: loopback mode
        tag = "R4";
        wr(3'd1, 8'hF0);
        wr(3'd5, 8'h01);
        rand_frame(256, 0);

        // R7: mid-frame realignment
        tag = "R7";
        rand_frame(100, 0);
        rand_frame(300, 0);

        // R8: unused addresses ignored
        tag = "R8";
        wr(3'd5, 8'h00);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        rand_frame(256, 0);
        wr(3'd7, 8'h01);
        rand_frame(256, 0);

        // Random frames with writes mixed in
        tag = "RND";
        for (int f = 0; f < 12; f++) rand_frame(256, 1);
        step(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule